// File: doc/BRIEF.md
# CAN Message Mailbox Bank with FIFO Mode

This block stores the message buffers of a CAN controller: 32 slots, each with a 29-bit identifier, an extended-format flag (IDE), a remote-request flag (RTR), a 4-bit length code and 64 data bits. A CPU port writes and reads whole slots. A transmit side takes frames from the bank, and a receive side delivers frames into it. Bit timing, arbitration, acceptance filtering and the bus protocol engine sit outside this block.

A configuration mode selects one of two layouts. In the normal layout all 32 slots are independent. In the queued layout, slots 0 to 23 stay independent, slots 24 to 27 become a 4-entry transmit queue and slots 28 to 31 become a 4-entry receive queue. The CPU reaches each queue through one window address. Writing slot 24 appends to the transmit queue. Reading slot 28 shows the receive head, and a release bit advances it. The layout lives in a two-state machine: `ST_NORMAL` and `ST_FIFO`. The transition `T_ENTER_FIFO` is taken on an accepted configuration write with the mode bit at 1, and `T_LEAVE_FIFO` on an accepted write with the mode bit at 0. Either transition empties both queues.

A global 2-bit ID-format field decides how the IDE flag of every stored frame is formed. The same field decides whether the upper identifier bits are kept.

Top module: `can_mbx_bank`

## Requirements
- R1: After reset, the layout is normal, the pin enable is 0, the ID format is 00, both queues are empty with no overflow, `mkiv_q` is 0 and `tx_valid` is 0.
- R2: A configuration write (`cfg_we`) changes the layout, pin enable and ID format only while `ctl_reset_mode` is 1. At any other time it is ignored.
- R3: A configuration write that carries ID format 11 is rejected as a whole, even in reset mode.
- R4: In the normal layout, a write to any slot 0 to 31 is read back from that slot from the next cycle onward, and it leaves every other slot unchanged.
- R5: The stored IDE is formed from the ID format: 00 forces it to 0, 01 forces it to 1, and 10 keeps the writer's IDE. When the stored IDE is 0, identifier bits 28:11 are stored as 0.
- R6: In the queued layout, CPU writes to slot 24 append to the transmit queue. `tx_valid` is 1 whenever that queue holds a frame. The `tx_*` outputs show the oldest frame, and `tx_pop` removes it, so frames leave in the order they were written.
- R7: In the queued layout, `rx_push` appends a frame to the receive queue. A read of slot 28 returns the oldest frame, or all zeros when the queue is empty. A `fctl_we` with `fctl_sel`=1 and `fctl_wdata[0]`=1 removes that frame. A release on an empty queue has no effect.
- R8: A queue reports full at 4 entries. A transmit-window write or receive push into a full queue is discarded and sets that queue's overflow flag. A `fctl_we` with `fctl_wdata[1]`=1 clears the flag of the queue that `fctl_sel` selects (0 = transmit, 1 = receive).
- R9: These actions are ignored: `rx_push` and `tx_pop` in the normal layout, `tx_pop` on an empty queue, and in the queued layout CPU writes to slots 25 to 31. In the queued layout, reads of slots 24 to 27 and 29 to 31 return all zeros.
- R10: In the normal layout, all 32 mask-invalid bits are held and read back. In the queued layout, bits 31:24 read as 0 and writes to them are dropped.
- R11: A change of layout empties both queues and clears both overflow flags in the same cycle that the layout changes.
- R12: In the queued layout with ID format 10, a received frame takes its IDE from the receive-queue IDE register (`rxf_ide_we`/`rxf_ide_d`) as it stood when the frame was pushed.
- R13: In the queued layout, slots 0 to 23 keep working as independent slots and keep the contents they held before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_reset_mode | input | 1 | Controller is in reset mode; gates configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fifo_mode_d | input | 1 | Layout to write (1 = queued) |
| cfg_pin_en_d | input | 1 | Pin enable to write |
| cfg_idfmt_d | input | 2 | ID format to write |
| cfg_fifo_mode | output | 1 | Current layout |
| cfg_pin_en | output | 1 | Current pin enable |
| cfg_idfmt | output | 2 | Current ID format |
| rxf_ide_we | input | 1 | Receive-queue IDE register write strobe |
| rxf_ide_d | input | 1 | Receive-queue IDE value |
| mkiv_we | input | 1 | Mask-invalid register write strobe |
| mkiv_d | input | 32 | Mask-invalid write data |
| mkiv_q | output | 32 | Mask-invalid read data |
| mb_we | input | 1 | CPU slot write strobe |
| mb_addr | input | 5 | CPU slot address (write and read) |
| mb_wid | input | 29 | Write identifier |
| mb_wide | input | 1 | Write IDE |
| mb_wrtr | input | 1 | Write RTR |
| mb_wdlc | input | 4 | Write length code |
| mb_wdata | input | 64 | Write data bytes |
| mb_rid | output | 29 | Read identifier |
| mb_ride | output | 1 | Read IDE |
| mb_rrtr | output | 1 | Read RTR |
| mb_rdlc | output | 4 | Read length code |
| mb_rdata | output | 64 | Read data bytes |
| fctl_we | input | 1 | Queue control write strobe |
| fctl_sel | input | 1 | Queue select: 0 transmit, 1 receive |
| fctl_wdata | input | 2 | Bit 0 release (receive), bit 1 clear overflow |
| txf_empty | output | 1 | Transmit queue empty |
| txf_full | output | 1 | Transmit queue full |
| txf_ovf | output | 1 | Transmit queue overflow |
| rxf_empty | output | 1 | Receive queue empty |
| rxf_full | output | 1 | Receive queue full |
| rxf_ovf | output | 1 | Receive queue overflow |
| tx_pop | input | 1 | Remove transmit head |
| tx_valid | output | 1 | Transmit head present |
| tx_id | output | 29 | Transmit head identifier |
| tx_ide | output | 1 | Transmit head IDE |
| tx_rtr | output | 1 | Transmit head RTR |
| tx_dlc | output | 4 | Transmit head length code |
| tx_data | output | 64 | Transmit head data |
| rx_push | input | 1 | Deliver a received frame |
| rx_id | input | 29 | Received identifier |
| rx_rtr | input | 1 | Received RTR |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data |

## Verification
Some properties are checked on every cycle. Configuration holds while the controller is out of reset mode. The reserved ID format never appears. No queue is full and empty at once. A push into a full receive queue raises its overflow flag. Any change of layout leaves both queues empty. The upper mask-invalid bits read as zero in the queued layout. Other behaviours show only through the bench's scenarios: first-in first-out ordering through the two windows, the IDE and identifier masking under each format, discarded writes, a pop or release on an empty queue, and slot contents surviving a change of layout.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;

    localparam int ID_W     = 29;
    localparam int STD_ID_W = 11;
    localparam int DLC_W    = 4;
    localparam int DATA_W   = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam int FRAME_W = $bits(frame_t);

    typedef enum logic [1:0] {
        IDF_STD = 2'b00,
        IDF_EXT = 2'b01,
        IDF_MIX = 2'b10,
        IDF_RSV = 2'b11
    } idfmt_e;

    // Forms the stored IDE flag and trims the identifier for base-format frames.
    function automatic frame_t apply_idfmt(frame_t f, logic [1:0] fmt, logic mixed_ide);
        frame_t r;
        r = f;
        case (fmt)
            IDF_STD: r.ide = 1'b0;
            IDF_EXT: r.ide = 1'b1;
            default: r.ide = mixed_ide;
        endcase
        if (!r.ide) r.id[ID_W-1:STD_ID_W] = '0;
        return r;
    endfunction

endpackage

// File: rtl/can_mbx_cfg.sv
module can_mbx_cfg
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB   = 32,
    parameter int TXF_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_reset_mode,
    input  logic              cfg_we,
    input  logic              cfg_fifo_mode_d,
    input  logic              cfg_pin_en_d,
    input  logic [1:0]        cfg_idfmt_d,
    input  logic              rxf_ide_we,
    input  logic              rxf_ide_d,
    input  logic              mkiv_we,
    input  logic [NUM_MB-1:0] mkiv_d,
    output logic              fifo_mode,
    output logic              pin_en,
    output logic [1:0]        idfmt,
    output logic              rxf_ide,
    output logic [NUM_MB-1:0] mkiv_q,
    output logic              mode_chg
);

    localparam logic [NUM_MB-1:0] LOW_KEEP = {NUM_MB{1'b1}} >> (NUM_MB - TXF_BASE);

    typedef enum logic {
        ST_NORMAL = 1'b0,
        ST_FIFO   = 1'b1
    } mode_st_e;

    mode_st_e          state, state_nxt;
    logic              accept;
    logic [NUM_MB-1:0] keep_mask;
    logic [NUM_MB-1:0] mkiv_r;

    assign accept = cfg_we && ctl_reset_mode && (cfg_idfmt_d != IDF_RSV);

    // Transitions: T_ENTER_FIFO and T_LEAVE_FIFO
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_NORMAL: if (accept && cfg_fifo_mode_d)  state_nxt = ST_FIFO;
            ST_FIFO:   if (accept && !cfg_fifo_mode_d) state_nxt = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_nxt;
    end

    always_comb begin
        fifo_mode = (state == ST_FIFO);
        mode_chg  = (state_nxt != state);
        keep_mask = fifo_mode ? LOW_KEEP : {NUM_MB{1'b1}};
        mkiv_q    = mkiv_r & keep_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en  <= 1'b0;
            idfmt   <= IDF_STD;
            rxf_ide <= 1'b0;
            mkiv_r  <= '0;
        end else begin
            if (accept) begin
                pin_en <= cfg_pin_en_d;
                idfmt  <= cfg_idfmt_d;
            end
            if (rxf_ide_we) rxf_ide <= rxf_ide_d;
            if (mkiv_we)    mkiv_r  <= mkiv_d & keep_mask;
        end
    end

endmodule

// File: rtl/can_mbx_fifo_ptr.sv
module can_mbx_fifo_ptr #(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic                     pop,
    input  logic                     ovf_clr,
    output logic [$clog2(DEPTH)-1:0] wr_idx,
    output logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic                     empty,
    output logic                     full,
    output logic                     ovf
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
            if (do_pop)  rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            if (push && full) ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/can_mbx_bank.sv
module can_mbx_bank
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_reset_mode,
    input  logic                       cfg_we,
    input  logic                       cfg_fifo_mode_d,
    input  logic                       cfg_pin_en_d,
    input  logic [1:0]                 cfg_idfmt_d,
    output logic                       cfg_fifo_mode,
    output logic                       cfg_pin_en,
    output logic [1:0]                 cfg_idfmt,
    input  logic                       rxf_ide_we,
    input  logic                       rxf_ide_d,
    input  logic                       mkiv_we,
    input  logic [NUM_MB-1:0]          mkiv_d,
    output logic [NUM_MB-1:0]          mkiv_q,
    input  logic                       mb_we,
    input  logic [$clog2(NUM_MB)-1:0]  mb_addr,
    input  logic [ID_W-1:0]            mb_wid,
    input  logic                       mb_wide,
    input  logic                       mb_wrtr,
    input  logic [DLC_W-1:0]           mb_wdlc,
    input  logic [DATA_W-1:0]          mb_wdata,
    output logic [ID_W-1:0]            mb_rid,
    output logic                       mb_ride,
    output logic                       mb_rrtr,
    output logic [DLC_W-1:0]           mb_rdlc,
    output logic [DATA_W-1:0]          mb_rdata,
    input  logic                       fctl_we,
    input  logic                       fctl_sel,
    input  logic [1:0]                 fctl_wdata,
    output logic                       txf_empty,
    output logic                       txf_full,
    output logic                       txf_ovf,
    output logic                       rxf_empty,
    output logic                       rxf_full,
    output logic                       rxf_ovf,
    input  logic                       tx_pop,
    output logic                       tx_valid,
    output logic [ID_W-1:0]            tx_id,
    output logic                       tx_ide,
    output logic                       tx_rtr,
    output logic [DLC_W-1:0]           tx_dlc,
    output logic [DATA_W-1:0]          tx_data,
    input  logic                       rx_push,
    input  logic [ID_W-1:0]            rx_id,
    input  logic                       rx_rtr,
    input  logic [DLC_W-1:0]           rx_dlc,
    input  logic [DATA_W-1:0]          rx_data
);

    localparam int AW       = $clog2(NUM_MB);
    localparam int PW       = $clog2(FIFO_DEPTH);
    localparam int TXF_BASE = NUM_MB - 2 * FIFO_DEPTH;
    localparam int RXF_BASE = NUM_MB - FIFO_DEPTH;

    logic          fifo_mode, mode_chg, rxf_ide;
    logic [1:0]    idfmt;
    logic [PW-1:0] tx_wr_idx, tx_rd_idx, rx_wr_idx, rx_rd_idx;
    logic          addr_in_fifo, addr_is_txw, addr_is_rxw;
    logic          plain_we, tx_push_q, tx_pop_q, rx_push_q, rx_rel;
    logic          tx_oclr, rx_oclr;
    logic [AW-1:0] tx_wslot, tx_rslot, rx_wslot, rx_rslot;
    frame_t        wfix, rfix, rd_frame, tx_frame;
    frame_t        mem [NUM_MB];

    can_mbx_cfg #(.NUM_MB(NUM_MB), .TXF_BASE(TXF_BASE)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_reset_mode (ctl_reset_mode),
        .cfg_we         (cfg_we),
        .cfg_fifo_mode_d(cfg_fifo_mode_d),
        .cfg_pin_en_d   (cfg_pin_en_d),
        .cfg_idfmt_d    (cfg_idfmt_d),
        .rxf_ide_we     (rxf_ide_we),
        .rxf_ide_d      (rxf_ide_d),
        .mkiv_we        (mkiv_we),
        .mkiv_d         (mkiv_d),
        .fifo_mode      (fifo_mode),
        .pin_en         (cfg_pin_en),
        .idfmt          (idfmt),
        .rxf_ide        (rxf_ide),
        .mkiv_q         (mkiv_q),
        .mode_chg       (mode_chg)
    );

    assign cfg_fifo_mode = fifo_mode;
    assign cfg_idfmt     = idfmt;

    // Address decode and request qualification
    assign addr_in_fifo = (mb_addr >= AW'(TXF_BASE));
    assign addr_is_txw  = (mb_addr == AW'(TXF_BASE));
    assign addr_is_rxw  = (mb_addr == AW'(RXF_BASE));
    assign plain_we     = mb_we && !(fifo_mode && addr_in_fifo);
    assign tx_push_q    = mb_we && fifo_mode && addr_is_txw;
    assign tx_pop_q     = tx_pop && fifo_mode;
    assign rx_push_q    = rx_push && fifo_mode;
    assign rx_rel       = fctl_we && fctl_sel && fctl_wdata[0] && fifo_mode;
    assign tx_oclr      = fctl_we && !fctl_sel && fctl_wdata[1];
    assign rx_oclr      = fctl_we && fctl_sel && fctl_wdata[1];

    can_mbx_fifo_ptr #(.DEPTH(FIFO_DEPTH)) u_txf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mode_chg),
        .push   (tx_push_q),
        .pop    (tx_pop_q),
        .ovf_clr(tx_oclr),
        .wr_idx (tx_wr_idx),
        .rd_idx (tx_rd_idx),
        .empty  (txf_empty),
        .full   (txf_full),
        .ovf    (txf_ovf)
    );

    can_mbx_fifo_ptr #(.DEPTH(FIFO_DEPTH)) u_rxf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mode_chg),
        .push   (rx_push_q),
        .pop    (rx_rel),
        .ovf_clr(rx_oclr),
        .wr_idx (rx_wr_idx),
        .rd_idx (rx_rd_idx),
        .empty  (rxf_empty),
        .full   (rxf_full),
        .ovf    (rxf_ovf)
    );

    assign tx_wslot = AW'(TXF_BASE) + AW'(tx_wr_idx);
    assign tx_rslot = AW'(TXF_BASE) + AW'(tx_rd_idx);
    assign rx_wslot = AW'(RXF_BASE) + AW'(rx_wr_idx);
    assign rx_rslot = AW'(RXF_BASE) + AW'(rx_rd_idx);

    always_comb begin
        wfix = apply_idfmt('{id: mb_wid, ide: mb_wide, rtr: mb_wrtr, dlc: mb_wdlc, data: mb_wdata},
                           idfmt, mb_wide);
        rfix = apply_idfmt('{id: rx_id, ide: 1'b0, rtr: rx_rtr, dlc: rx_dlc, data: rx_data},
                           idfmt, rxf_ide);
    end

    // Slot storage: CPU port and receive push never target the same slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MB; i++) mem[i] <= '0;
        end else begin
            if (plain_we)               mem[mb_addr]  <= wfix;
            if (tx_push_q && !txf_full) mem[tx_wslot] <= wfix;
            if (rx_push_q && !rxf_full) mem[rx_wslot] <= rfix;
        end
    end

    always_comb begin
        rd_frame = mem[mb_addr];
        if (fifo_mode && addr_in_fifo) begin
            rd_frame = (addr_is_rxw && !rxf_empty) ? mem[rx_rslot] : '0;
        end
    end

    assign mb_rid   = rd_frame.id;
    assign mb_ride  = rd_frame.ide;
    assign mb_rrtr  = rd_frame.rtr;
    assign mb_rdlc  = rd_frame.dlc;
    assign mb_rdata = rd_frame.data;

    assign tx_frame = mem[tx_rslot];
    assign tx_valid = fifo_mode && !txf_empty;
    assign tx_id    = tx_frame.id;
    assign tx_ide   = tx_frame.ide;
    assign tx_rtr   = tx_frame.rtr;
    assign tx_dlc   = tx_frame.dlc;
    assign tx_data  = tx_frame.data;

endmodule

// File: rtl/can_mbx_bank_chk.sv
module can_mbx_bank_chk #(
    parameter int NUM_MB   = 32,
    parameter int TXF_BASE = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_reset_mode,
    input logic              cfg_we,
    input logic              cfg_fifo_mode,
    input logic              cfg_pin_en,
    input logic [1:0]        cfg_idfmt,
    input logic              txf_empty,
    input logic              txf_full,
    input logic              txf_ovf,
    input logic              rxf_empty,
    input logic              rxf_full,
    input logic              rxf_ovf,
    input logic              rx_push,
    input logic              rx_ovf_clr,
    input logic [NUM_MB-1:0] mkiv_q
);

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_reset_mode |=> $stable(cfg_fifo_mode) && $stable(cfg_pin_en) && $stable(cfg_idfmt));

    a_r3_no_reserved_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_idfmt != 2'b11);

    a_r8_tx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(txf_full && txf_empty));

    a_r8_rx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rxf_full && rxf_empty));

    a_r8_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo_mode && rxf_full && rx_push && !rx_ovf_clr && !(cfg_we && ctl_reset_mode)
        |=> rxf_ovf);

    a_r11_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_fifo_mode) |-> txf_empty && rxf_empty && !txf_ovf && !rxf_ovf);

    a_r10_mkiv_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo_mode |-> (mkiv_q >> TXF_BASE) == '0);

endmodule

bind can_mbx_bank can_mbx_bank_chk #(.NUM_MB(NUM_MB), .TXF_BASE(TXF_BASE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_reset_mode(ctl_reset_mode),
    .cfg_we        (cfg_we),
    .cfg_fifo_mode (cfg_fifo_mode),
    .cfg_pin_en    (cfg_pin_en),
    .cfg_idfmt     (cfg_idfmt),
    .txf_empty     (txf_empty),
    .txf_full      (txf_full),
    .txf_ovf       (txf_ovf),
    .rxf_empty     (rxf_empty),
    .rxf_full      (rxf_full),
    .rxf_ovf       (rxf_ovf),
    .rx_push       (rx_push),
    .rx_ovf_clr    (fctl_we && fctl_sel && fctl_wdata[1]),
    .mkiv_q        (mkiv_q)
);

// File: tb/can_mbx_bank_tb.sv
module can_mbx_bank_tb;
    import can_mbx_pkg::*;

    localparam logic [4:0] TXW = 5'd24;
    localparam logic [4:0] RXW = 5'd28;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, ctl_reset_mode, cfg_we, cfg_fifo_mode_d, cfg_pin_en_d;
    logic [1:0]  cfg_idfmt_d, cfg_idfmt, fctl_wdata;
    logic        cfg_fifo_mode, cfg_pin_en, rxf_ide_we, rxf_ide_d, mkiv_we;
    logic [31:0] mkiv_d, mkiv_q;
    logic        mb_we, mb_wide, mb_wrtr, mb_ride, mb_rrtr;
    logic [4:0]  mb_addr;
    logic [28:0] mb_wid, mb_rid, tx_id, rx_id;
    logic [3:0]  mb_wdlc, mb_rdlc, tx_dlc, rx_dlc;
    logic [63:0] mb_wdata, mb_rdata, tx_data, rx_data;
    logic        fctl_we, fctl_sel;
    logic        txf_empty, txf_full, txf_ovf, rxf_empty, rxf_full, rxf_ovf;
    logic        tx_pop, tx_valid, tx_ide, tx_rtr, rx_push, rx_rtr;

    can_mbx_bank u_dut (.*);

    int     n_run = 0, n_fail = 0;
    bit     done  = 0;
    frame_t txq[$], rxq[$];
    logic [1:0] cur_fmt = 2'b00;
    logic       cur_rxide = 1'b0;

    function automatic frame_t expect_fix(frame_t f, logic [1:0] fmt, logic src);
        frame_t r;
        r = f;
        r.ide = (fmt == 2'b10) ? src : (fmt == 2'b01);
        if (!r.ide) r.id = r.id & 29'h7FF;
        return r;
    endfunction

    function automatic frame_t mk(int s);
        frame_t f;
        f.id   = 29'(s * 32'h0137_9A5B + 32'h0123_4567);
        f.ide  = s[0];
        f.rtr  = s[1];
        f.dlc  = 4'(s % 9);
        f.data = {32'(s * 32'h9E37_79B9), ~32'(s)};
        return f;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic do_cfg(logic rm, logic mode, logic pin, logic [1:0] fmt);
        ctl_reset_mode = rm; cfg_we = 1'b1;
        cfg_fifo_mode_d = mode; cfg_pin_en_d = pin; cfg_idfmt_d = fmt;
        @(negedge clk);
        cfg_we = 1'b0; ctl_reset_mode = 1'b0;
    endtask

    task automatic do_mbw(logic [4:0] a, frame_t f);
        mb_we = 1'b1; mb_addr = a;
        mb_wid = f.id; mb_wide = f.ide; mb_wrtr = f.rtr; mb_wdlc = f.dlc; mb_wdata = f.data;
        @(negedge clk);
        mb_we = 1'b0;
    endtask

    task automatic do_mbr(logic [4:0] a, output frame_t f);
        mb_addr = a;
        #1;
        f.id = mb_rid; f.ide = mb_ride; f.rtr = mb_rrtr; f.dlc = mb_rdlc; f.data = mb_rdata;
    endtask

    task automatic do_fctl(logic sel, logic [1:0] d);
        fctl_we = 1'b1; fctl_sel = sel; fctl_wdata = d;
        @(negedge clk);
        fctl_we = 1'b0;
    endtask

    task automatic set_rxide(logic v);
        rxf_ide_we = 1'b1; rxf_ide_d = v;
        @(negedge clk);
        rxf_ide_we = 1'b0; cur_rxide = v;
    endtask

    // Driver: transmit-window write, expected frame into the scoreboard
    task automatic tx_write(frame_t f, bit keep);
        if (keep) txq.push_back(expect_fix(f, cur_fmt, f.ide));
        do_mbw(TXW, f);
    endtask

    task automatic rx_in(frame_t f, bit keep);
        if (keep) rxq.push_back(expect_fix(f, cur_fmt, cur_rxide));
        rx_push = 1'b1; rx_id = f.id; rx_rtr = f.rtr; rx_dlc = f.dlc; rx_data = f.data;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Monitor: compare transmit head with scoreboard, then pop
    task automatic tx_take(string tag);
        frame_t e, g;
        #1;
        e = txq.pop_front();
        g.id = tx_id; g.ide = tx_ide; g.rtr = tx_rtr; g.dlc = tx_dlc; g.data = tx_data;
        chk({tag, " tx_valid"}, 128'(tx_valid), 128'(1));
        chk({tag, " tx head"}, 128'(g), 128'(e));
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rx_take(string tag);
        frame_t e, g;
        e = rxq.pop_front();
        do_mbr(RXW, g);
        chk({tag, " rx window"}, 128'(g), 128'(e));
        do_fctl(1'b1, 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        frame_t g;
        rst_n = 0; ctl_reset_mode = 0; cfg_we = 0; cfg_fifo_mode_d = 0; cfg_pin_en_d = 0;
        cfg_idfmt_d = 0; rxf_ide_we = 0; rxf_ide_d = 0; mkiv_we = 0; mkiv_d = 0;
        mb_we = 0; mb_addr = 0; mb_wid = 0; mb_wide = 0; mb_wrtr = 0; mb_wdlc = 0; mb_wdata = 0;
        fctl_we = 0; fctl_sel = 0; fctl_wdata = 0; tx_pop = 0;
        rx_push = 0; rx_id = 0; rx_rtr = 0; rx_dlc = 0; rx_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cfg", 128'({cfg_fifo_mode, cfg_pin_en, cfg_idfmt}), 128'(0));
        chk("R1 flags", 128'({txf_empty, txf_full, txf_ovf, rxf_empty, rxf_full, rxf_ovf}),
            128'(6'b100_100));
        chk("R1 mkiv", 128'(mkiv_q), 128'(0));
        chk("R1 tx_valid", 128'(tx_valid), 128'(0));

        // R2 write outside reset mode ignored; R3 reserved format rejected
        do_cfg(1'b0, 1'b1, 1'b1, 2'b10);
        chk("R2 ignored", 128'({cfg_fifo_mode, cfg_pin_en, cfg_idfmt}), 128'(0));
        do_cfg(1'b1, 1'b1, 1'b1, 2'b11);
        chk("R3 rejected", 128'({cfg_fifo_mode, cfg_pin_en, cfg_idfmt}), 128'(0));

        // R4/R5 all 32 slots in normal layout, standard-only format
        for (int i = 0; i < 32; i++) do_mbw(5'(i), mk(i + 1));
        for (int i = 0; i < 32; i++) begin
            do_mbr(5'(i), g);
            chk($sformatf("R4 R5 slot %0d", i), 128'(g), 128'(expect_fix(mk(i + 1), 2'b00, 1'b0)));
        end

        // R9 receive push in normal layout ignored
        rx_in(mk(200), 0);
        chk("R9 rx ignored normal", 128'(rxf_empty), 128'(1));

        // R10 normal mask bits
        mkiv_we = 1; mkiv_d = 32'hFFFF_FFFF; @(negedge clk); mkiv_we = 0;
        chk("R10 mkiv normal", 128'(mkiv_q), 128'(32'hFFFF_FFFF));

        // R2 accepted write: enter queued layout, mixed format
        do_cfg(1'b1, 1'b1, 1'b1, 2'b10);
        cur_fmt = 2'b10;
        chk("R2 accepted", 128'({cfg_fifo_mode, cfg_pin_en, cfg_idfmt}), 128'(4'b1110));
        chk("R10 mkiv fifo read", 128'(mkiv_q), 128'(32'h00FF_FFFF));
        mkiv_we = 1; mkiv_d = 32'hA5A5_A5A5; @(negedge clk); mkiv_we = 0;
        chk("R10 mkiv fifo write", 128'(mkiv_q), 128'(32'h00A5_A5A5));

        // R13 independent slots still usable and preserved
        do_mbr(5'd23, g);
        chk("R13 slot 23 kept", 128'(g), 128'(expect_fix(mk(24), 2'b00, 1'b0)));
        do_mbw(5'd5, mk(90));
        do_mbr(5'd5, g);
        chk("R13 R5 slot 5 mixed", 128'(g), 128'(expect_fix(mk(90), 2'b10, mk(90).ide)));

        // R6/R8/R9 transmit queue
        for (int i = 0; i < 4; i++) tx_write(mk(50 + i), 1);
        chk("R8 tx full", 128'({txf_full, txf_empty}), 128'(2'b10));
        tx_write(mk(60), 0);
        chk("R8 tx overflow", 128'(txf_ovf), 128'(1));
        do_mbw(5'd26, mk(61));
        do_mbr(TXW, g);
        chk("R9 tx window read zero", 128'(g), 128'(0));
        do_mbr(5'd26, g);
        chk("R9 slot 26 read zero", 128'(g), 128'(0));
        for (int i = 0; i < 4; i++) tx_take("R6");
        chk("R6 R9 tx drained", 128'({tx_valid, txf_empty}), 128'(2'b01));
        tx_pop = 1; @(negedge clk); tx_pop = 0;
        chk("R9 pop on empty", 128'({txf_empty, txf_full}), 128'(2'b10));
        tx_write(mk(70), 1);
        tx_take("R9 after empty pop");
        do_fctl(1'b0, 2'b10);
        chk("R8 tx ovf clear", 128'(txf_ovf), 128'(0));

        // R7/R8/R12 receive queue
        set_rxide(1'b1);
        rx_in(mk(80), 1); rx_in(mk(81), 1);
        set_rxide(1'b0);
        rx_in(mk(82), 1); rx_in(mk(83), 1);
        chk("R8 rx full", 128'({rxf_full, rxf_empty}), 128'(2'b10));
        rx_in(mk(84), 0);
        chk("R8 rx overflow", 128'(rxf_ovf), 128'(1));
        do_mbr(5'd29, g);
        chk("R9 slot 29 read zero", 128'(g), 128'(0));
        for (int i = 0; i < 4; i++) rx_take("R7 R12");
        chk("R7 rx drained", 128'(rxf_empty), 128'(1));
        do_mbr(RXW, g);
        chk("R7 empty window zero", 128'(g), 128'(0));
        do_fctl(1'b1, 2'b01);
        chk("R7 release on empty", 128'({rxf_empty, rxf_full}), 128'(2'b10));
        rx_in(mk(85), 1);
        rx_take("R7 after empty release");
        do_fctl(1'b1, 2'b10);
        chk("R8 rx ovf clear", 128'(rxf_ovf), 128'(0));

        // R11 layout change empties both queues
        tx_write(mk(95), 0); tx_write(mk(96), 0);
        for (int i = 0; i < 5; i++) rx_in(mk(97 + i), 0);
        chk("R11 pre state", 128'({txf_empty, rxf_full, rxf_ovf}), 128'(3'b011));
        do_cfg(1'b1, 1'b0, 1'b1, 2'b10);
        chk("R11 cleared", 128'({cfg_fifo_mode, txf_empty, rxf_empty, txf_ovf, rxf_ovf}),
            128'(5'b01100));
        tx_pop = 1; @(negedge clk); tx_pop = 0;
        do_cfg(1'b1, 1'b1, 1'b1, 2'b10);
        chk("R11 R9 re-entry empty", 128'({tx_valid, txf_empty, rxf_empty}), 128'(3'b011));

        // R5 extended-only format in normal layout
        do_cfg(1'b1, 1'b0, 1'b0, 2'b01);
        cur_fmt = 2'b01;
        g = mk(120); g.ide = 1'b0;
        do_mbw(5'd3, g);
        do_mbr(5'd3, g);
        chk("R5 extended forced", 128'(g), 128'(expect_fix(mk(120), 2'b01, 1'b0)));

        report();
    end

endmodule